// File: doc/BRIEF.md
# Latched Interrupt Aggregator

This block collects four board-level interrupt sources, holds each one in a latch, and drives a single combined interrupt line to a host processor. Each source is active high. The four sources are a wireless UART detect, a serial ring indicator, a card detect and a 5 V supply failure. The host reaches the block over a simple byte-wide register bus. It sees two registers: one that masks and unmasks sources, and one that reports which latches are set and also accepts acknowledge writes.

The status register uses inverted sense: a latched source reads as 0. Software therefore takes the inverse of the status value, ANDs it with the enable mask, and handles the sources that result. An acknowledge clears a latch only when its source has already gone away. If the source is still active, the latch sets again at once. The host watches the combined line for rising edges. A normal start-up writes 0x00 to the enable register and then 0xFF to the acknowledge register.

Top module: `irq_latch_ctrl`

## Requirements
- R1: After reset, the status register reads 0xFF, the enable register reads 0x00 and `irq_out` is low.
- R2: Each source input passes through a two-flop synchroniser. When a source input is high, its latch is set. The status bit goes to 0 after the third rising clock edge that follows the input change, and not after the second. Bit positions are: 0 wireless UART detect, 1 ring indicator, 2 card detect, 3 supply fail.
- R3: A set latch stays set after its source drops, until an acknowledge clears it.
- R4: Writing 1 to a bit at byte offset 0x0C clears that latch only if the synchronised source is low. While the source is high, the write has no effect, because setting wins over clearing.
- R5: A write to offset 0x0C leaves untouched every latch whose data bit is 0.
- R6: The enable register at offset 0x0E reads back bits 3:0 exactly as written, and its bits 7:4 read 0. Status bits 7:4 always read 1.
- R7: `irq_out` is high exactly when at least one latched source is also enabled. A masked source still latches, and its status bit still shows as pending.
- R8: Once every enabled latch is cleared, `irq_out` returns low, so a later event produces a fresh rising edge.
- R9: Writes to any other offset leave the latches and the enable register unchanged, and reads of other offsets return 0x00. With `bus_rd` low, `bus_rdata` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_in | input | NSRC | Active-high interrupt source levels, not synchronised |
| bus_addr | input | AW | Byte offset of the register access |
| bus_wr | input | 1 | Write strobe, sampled on the clock edge |
| bus_wdata | input | DW | Write data |
| bus_rd | input | 1 | Read strobe; read data is combinational |
| bus_rdata | output | DW | Read data |
| irq_out | output | 1 | Combined interrupt to the host, active high |

## Verification
The checker tests the following on every cycle:
- a synchronised active source always leaves its latch set on the next cycle, whatever was written;
- latches never drop unless an acknowledge write targets them;
- an acknowledge of an idle source always clears its latch;
- stray writes disturb neither register;
- `irq_out` is low while nothing is enabled.

Some behaviour can only be shown by the bench's scenarios, because it depends on how the host sees the block over time:
- the exact three-edge latency from a pin change to the status bit;
- the inverted read-back encoding;
- a masked latch turning into an interrupt once it is unmasked;
- the fresh rising edge after a complete clear.

// File: rtl/irq_latch_ctrl.sv
module irq_latch_ctrl #(
  parameter int unsigned NSRC    = 4,
  parameter int unsigned AW      = 5,
  parameter int unsigned DW      = 8,
  parameter logic [AW-1:0] CLR_OFS = 5'h0C,
  parameter logic [AW-1:0] EN_OFS  = 5'h0E
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_in,
  input  logic [AW-1:0]   bus_addr,
  input  logic            bus_wr,
  input  logic [DW-1:0]   bus_wdata,
  input  logic            bus_rd,
  output logic [DW-1:0]   bus_rdata,
  output logic            irq_out
);

  logic [NSRC-1:0] sync1, sync2, pend, en;
  logic [DW-1:0]   status_v, enable_v;

  wire clr_hit = bus_wr && (bus_addr == CLR_OFS);
  wire en_hit  = bus_wr && (bus_addr == EN_OFS);
  wire [NSRC-1:0] ack = clr_hit ? bus_wdata[NSRC-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
    end else begin
      sync1 <= src_in;
      sync2 <= sync1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= '0;
    else        pend <= sync2 | (pend & ~ack);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      en <= '0;
    else if (en_hit) en <= bus_wdata[NSRC-1:0];
  end

  always_comb begin
    status_v = '1;
    status_v[NSRC-1:0] = ~pend;
    enable_v = '0;
    enable_v[NSRC-1:0] = en;
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      if (bus_addr == CLR_OFS)     bus_rdata = status_v;
      else if (bus_addr == EN_OFS) bus_rdata = enable_v;
    end
  end

  assign irq_out = |(pend & en);

endmodule

module irq_latch_ctrl_chk #(
  parameter int unsigned NSRC    = 4,
  parameter int unsigned AW      = 5,
  parameter int unsigned DW      = 8,
  parameter logic [AW-1:0] CLR_OFS = 5'h0C,
  parameter logic [AW-1:0] EN_OFS  = 5'h0E
) (
  input logic            clk,
  input logic            rst_n,
  input logic [AW-1:0]   bus_addr,
  input logic            bus_wr,
  input logic [DW-1:0]   bus_wdata,
  input logic            irq_out,
  input logic [NSRC-1:0] pend,
  input logic [NSRC-1:0] sync2,
  input logic [NSRC-1:0] en
);
  wire clr_wr   = bus_wr && bus_addr == CLR_OFS;
  wire other_wr = bus_wr && bus_addr != CLR_OFS && bus_addr != EN_OFS;

  p_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sync2 != '0) |=> ((pend & $past(sync2)) == $past(sync2)));

  p_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_wr |=> ((pend & $past(pend)) == $past(pend)));

  p_ack_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wr |=> ((pend & $past(bus_wdata[NSRC-1:0] & ~sync2)) == '0));

  p_stray_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    other_wr |=> ($stable(en) && ((pend & $past(pend)) == $past(pend))));

  p_masked_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (en == '0) |-> !irq_out);
endmodule

bind irq_latch_ctrl irq_latch_ctrl_chk #(
  .NSRC(NSRC), .AW(AW), .DW(DW), .CLR_OFS(CLR_OFS), .EN_OFS(EN_OFS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .irq_out(irq_out), .pend(pend), .sync2(sync2), .en(en)
);

// File: tb/irq_latch_ctrl_tb.sv
module irq_latch_ctrl_tb;
  localparam logic [4:0] CLR = 5'h0C;
  localparam logic [4:0] ENR = 5'h0E;

  logic       clk = 0;
  logic       rst_n = 0;
  logic [3:0] src_in = '0;
  logic [4:0] bus_addr = '0;
  logic       bus_wr = 0;
  logic [7:0] bus_wdata = '0;
  logic       bus_rd = 0;
  logic [7:0] bus_rdata;
  logic       irq_out;

  int checks = 0;
  int fails  = 0;
  logic [3:0] exp_lat = '0;
  logic [3:0] exp_en  = '0;
  logic [7:0] rv;

  always #4 clk = ~clk;

  irq_latch_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .src_in(src_in), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rd(bus_rd),
    .bus_rdata(bus_rdata), .irq_out(irq_out)
  );

  function automatic logic [7:0] f_status(input logic [3:0] lat);
    return {4'hF, ~lat};
  endfunction

  function automatic logic f_irq(input logic [3:0] lat, input logic [3:0] e);
    return |(lat & e);
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1;
    #1 d = bus_rdata;
    bus_rd = 0;
  endtask

  task automatic set_src(input logic [3:0] v);
    @(negedge clk);
    src_in = v;
    repeat (4) @(negedge clk);
    exp_lat |= v;
  endtask

  task automatic check_all(input string req);
    rd(CLR, rv); chk(req, rv, f_status(exp_lat));
    rd(ENR, rv); chk(req, rv, {4'h0, exp_en});
    chk(req, {7'b0, irq_out}, {7'b0, f_irq(exp_lat, exp_en)});
  endtask

  initial begin
    #(8 * 150000);
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd(CLR, rv); chk("R1 status", rv, 8'hFF);
    rd(ENR, rv); chk("R1 enable", rv, 8'h00);
    chk("R1 irq", {7'b0, irq_out}, 8'h00);
    // R9 idle read bus
    #1 chk("R9 rd low", bus_rdata, 8'h00);

    // R2 latency: bit 2 (card detect)
    @(negedge clk); src_in = 4'b0100;
    bus_addr = CLR; bus_rd = 1;
    @(negedge clk); @(negedge clk);
    #1 chk("R2 not yet at edge 2", bus_rdata, 8'hFF);
    @(negedge clk);
    #1 chk("R2 latched at edge 3", bus_rdata, 8'hFB);
    bus_rd = 0;
    exp_lat = 4'b0100;
    // R7 masked source latched, no irq
    chk("R7 masked irq", {7'b0, irq_out}, 8'h00);
    // R4 set wins while source high
    wr(CLR, 8'hFF);
    rd(CLR, rv); chk("R4 set wins", rv, 8'hFB);
    // R3 hold after source drops
    @(negedge clk); src_in = 4'b0000;
    repeat (4) @(negedge clk);
    rd(CLR, rv); chk("R3 sticky", rv, 8'hFB);
    // R7 enable -> irq
    wr(ENR, 8'hF4); exp_en = 4'b0100;
    rd(ENR, rv); chk("R6 enable readback", rv, 8'h04);
    chk("R7 irq high", {7'b0, irq_out}, 8'h01);
    // R9 other offsets
    wr(5'h0A, 8'hFF); wr(5'h10, 8'h00);
    check_all("R9 stray write");
    rd(5'h06, rv); chk("R9 other read", rv, 8'h00);
    // R5 zero bits ignored
    wr(CLR, 8'hFB);
    rd(CLR, rv); chk("R5 zero bit", rv, 8'hFB);
    // R8 clear -> irq low, fresh edge
    wr(CLR, 8'h04); exp_lat = '0;
    chk("R8 irq low", {7'b0, irq_out}, 8'h00);
    rd(CLR, rv); chk("R4 cleared", rv, 8'hFF);
    set_src(4'b0100);
    chk("R8 fresh edge", {7'b0, irq_out}, 8'h01);
    set_src(4'b0000);
    wr(CLR, 8'hFF); exp_lat = '0;

    // random mix
    for (int i = 0; i < 200; i++) begin
      logic [3:0] s;
      logic [7:0] d;
      int op;
      s = 4'($urandom);
      set_src(s);
      op = int'($urandom % 4);
      d  = 8'($urandom);
      case (op)
        0: begin wr(CLR, d); exp_lat = (exp_lat & ~(d[3:0] & ~s)) | s; end
        1: begin wr(ENR, d); exp_en = d[3:0]; end
        2: wr(5'($urandom % 12), d);
        default: ;
      endcase
      check_all("R7 random");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule